// File: doc/BRIEF.md
# Dual-Rank Bus Shift Register

The block holds two equal-width ranks of storage side by side. Rank A is a parallel holding register that connects to a shared bidirectional data bus. Rank B is a serial shift register with a serial input and a serial output. On each rising clock edge the block can capture the bus into A, copy A into B, copy B into A, shift B by one place, or swap the two ranks. Any two compatible operations can also happen on the same edge. The bus is modelled as a separate input vector, an output vector and an output-enable, so a tri-state pad can be placed around it at chip level. The serial pins let several instances form one wider word.

Every control is active low, and its level matters only as sampled at the rising edge. Each cycle the control decoder picks one named action per rank:
- Rank A takes one of A_HOLD, A_LOAD or A_UP.
- Rank B takes one of B_HOLD, B_DOWN or B_SHIFT.

The chosen action is the transition taken by that rank's register on that edge. Driving the bus is independent of all transfers, and capturing the bus suppresses driving.

Top module: `dual_rank_shreg`

## Requirements
- R1: A synchronous active-high `rst` clears rank A and rank B to zero on the next rising edge, and it overrides every control.
- R2: With `cap_en_n` low, rank A takes `bus_in` on the rising edge (A_LOAD), whatever `up_en_n` is.
- R3: With `down_en_n` low, rank B takes the old value of rank A on the rising edge (B_DOWN), even when `shift_en_n` is also low.
- R4: With `up_en_n` low and `cap_en_n` high, rank A takes the old value of rank B (A_UP).
- R5: With `up_en_n` and `down_en_n` both low and `cap_en_n` high, the ranks swap on one edge: A gets the old B and B gets the old A.
- R6: With `shift_en_n` low and `down_en_n` high, B becomes {B[W-2:0], ser_in}. Bit 0 receives `ser_in`, and `ser_out` always shows bit W-1 of B.
- R7: `bus_oe` is high exactly when `drv_en_n` is low and `cap_en_n` is high. When both are low, capture wins and the bus is not driven. `bus_out` always presents rank A.
- R8: With `cap_en_n`, `up_en_n`, `down_en_n` and `shift_en_n` all high, both ranks hold their values, whatever `drv_en_n`, `bus_in` and `ser_in` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear of both ranks |
| drv_en_n | input | 1 | Active-low bus drive enable |
| cap_en_n | input | 1 | Active-low bus capture into rank A |
| up_en_n | input | 1 | Active-low copy of B into A |
| down_en_n | input | 1 | Active-low copy of A into B |
| shift_en_n | input | 1 | Active-low serial shift of B |
| bus_in | input | W | Bus value seen at the pins |
| bus_out | output | W | Value offered to the bus (rank A) |
| bus_oe | output | 1 | Bus driver enable |
| ser_in | input | 1 | Serial data into B bit 0 |
| ser_out | output | 1 | Serial data from B bit W-1 |

## Verification
Rank B cannot be seen at the ports except through its top bit, so a wrong value in its lower bits stays hidden until it is shifted out or moved up into A. The stimulus handles this in two ways. All 32 control combinations are applied with changing data, with a reference model tracking both ranks. Each directed scenario then ends by shifting B out through `ser_out` or moving it up to `bus_out`. The cases where both ranks are written at once need particular care, because an error there can look correct for a time: swap, capture together with swap, and copy-down together with shift each need their old values taken from before the edge.

// File: rtl/dual_rank_pkg.sv
package dual_rank_pkg;
    typedef enum logic [1:0] {
        A_HOLD  = 2'd0,
        A_LOAD  = 2'd1,
        A_UP    = 2'd2
    } a_op_e;

    typedef enum logic [1:0] {
        B_HOLD  = 2'd0,
        B_DOWN  = 2'd1,
        B_SHIFT = 2'd2
    } b_op_e;
endpackage

// File: rtl/dual_rank_ctrl.sv
module dual_rank_ctrl
    import dual_rank_pkg::*;
(
    input  logic  drv_en_n,
    input  logic  cap_en_n,
    input  logic  up_en_n,
    input  logic  down_en_n,
    input  logic  shift_en_n,
    output a_op_e a_op,
    output b_op_e b_op,
    output logic  bus_oe
);
    always_comb begin
        unique case ({cap_en_n, up_en_n})
            2'b00, 2'b01: a_op = A_LOAD;
            2'b10:        a_op = A_UP;
            default:      a_op = A_HOLD;
        endcase
    end

    always_comb begin
        unique case ({down_en_n, shift_en_n})
            2'b00, 2'b01: b_op = B_DOWN;
            2'b10:        b_op = B_SHIFT;
            default:      b_op = B_HOLD;
        endcase
    end

    always_comb begin
        bus_oe = (drv_en_n == 1'b0) && (cap_en_n == 1'b1);
    end
endmodule

// File: rtl/dual_rank_a.sv
module dual_rank_a
    import dual_rank_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  a_op_e        op,
    input  logic [W-1:0] bus_in,
    input  logic [W-1:0] b_q,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            unique case (op)
                A_LOAD:  q <= bus_in;
                A_UP:    q <= b_q;
                default: q <= q;
            endcase
        end
    end

    AST_A_LOAD: assert property (@(posedge clk) disable iff (rst)
        (op == A_LOAD) |=> (q == $past(bus_in))); // R2
    AST_A_UP: assert property (@(posedge clk) disable iff (rst)
        (op == A_UP) |=> (q == $past(b_q))); // R4
endmodule

// File: rtl/dual_rank_b.sv
module dual_rank_b
    import dual_rank_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  b_op_e        op,
    input  logic [W-1:0] a_q,
    input  logic         ser_in,
    output logic [W-1:0] q
);
    localparam int MSB = W - 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            unique case (op)
                B_DOWN:  q <= a_q;
                B_SHIFT: q <= {q[MSB-1:0], ser_in};
                default: q <= q;
            endcase
        end
    end

    AST_B_DOWN: assert property (@(posedge clk) disable iff (rst)
        (op == B_DOWN) |=> (q == $past(a_q))); // R3
    AST_B_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (op == B_SHIFT) |=> (q == {$past(q[MSB-1:0]), $past(ser_in)})); // R6
endmodule

// File: rtl/dual_rank_shreg.sv
module dual_rank_shreg
    import dual_rank_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         drv_en_n,
    input  logic         cap_en_n,
    input  logic         up_en_n,
    input  logic         down_en_n,
    input  logic         shift_en_n,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] bus_out,
    output logic         bus_oe,
    input  logic         ser_in,
    output logic         ser_out
);
    localparam int MSB = W - 1;

    a_op_e        a_op;
    b_op_e        b_op;
    logic [W-1:0] a_q;
    logic [W-1:0] b_q;

    dual_rank_ctrl u_ctrl (
        .drv_en_n   (drv_en_n),
        .cap_en_n   (cap_en_n),
        .up_en_n    (up_en_n),
        .down_en_n  (down_en_n),
        .shift_en_n (shift_en_n),
        .a_op       (a_op),
        .b_op       (b_op),
        .bus_oe     (bus_oe)
    );

    dual_rank_a #(.W(W)) u_a (
        .clk    (clk),
        .rst    (rst),
        .op     (a_op),
        .bus_in (bus_in),
        .b_q    (b_q),
        .q      (a_q)
    );

    dual_rank_b #(.W(W)) u_b (
        .clk    (clk),
        .rst    (rst),
        .op     (b_op),
        .a_q    (a_q),
        .ser_in (ser_in),
        .q      (b_q)
    );

    always_comb begin
        bus_out = a_q;
        ser_out = b_q[MSB];
    end

    AST_SWAP: assert property (@(posedge clk) disable iff (rst)
        (!up_en_n && !down_en_n && cap_en_n)
        |=> (a_q == $past(b_q)) && (b_q == $past(a_q))); // R5
    AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (rst)
        (!cap_en_n) |-> (!bus_oe)); // R7
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cap_en_n && up_en_n && down_en_n && shift_en_n)
        |=> $stable(a_q) && $stable(b_q)); // R8
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (a_q == '0) && (b_q == '0)); // R1
endmodule

// File: tb/sim_dual_rank_shreg.sv
module sim_dual_rank_shreg;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic drv_en_n = 1'b1, cap_en_n = 1'b1, up_en_n = 1'b1;
    logic down_en_n = 1'b1, shift_en_n = 1'b1;
    logic [W-1:0] bus_in = '0;
    logic [W-1:0] bus_out;
    logic bus_oe, ser_in = 1'b0, ser_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [W-1:0] ma = '0;
    logic [W-1:0] mb = '0;

    always #4 clk = ~clk;

    dual_rank_shreg #(.W(W)) u0 (
        .clk(clk), .rst(rst), .drv_en_n(drv_en_n), .cap_en_n(cap_en_n),
        .up_en_n(up_en_n), .down_en_n(down_en_n), .shift_en_n(shift_en_n),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .ser_in(ser_in), .ser_out(ser_out)
    );

    // Each entry: {drv_n, cap_n, up_n, down_n, shift_n, bus_in[7:0], ser_in}
    localparam logic [13:0] VEC [16] = '{
        {5'b10111, 8'hA5, 1'b0}, {5'b01110, 8'h00, 1'b1},
        {5'b11101, 8'h00, 1'b0}, {5'b11011, 8'h00, 1'b0},
        {5'b11001, 8'h00, 1'b0}, {5'b00111, 8'h3C, 1'b1},
        {5'b11100, 8'h00, 1'b1}, {5'b10001, 8'h81, 1'b0},
        {5'b01111, 8'hFF, 1'b1}, {5'b11110, 8'h00, 1'b1},
        {5'b10011, 8'h5A, 1'b0}, {5'b11010, 8'h00, 1'b1},
        {5'b01001, 8'h00, 1'b0}, {5'b10100, 8'hC3, 1'b1},
        {5'b11110, 8'h00, 1'b0}, {5'b01111, 8'h77, 1'b1}
    };

    task automatic check(input string tag, input logic [W-1:0] got,
                         input logic [W-1:0] exp, input string what);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic step(input logic [4:0] c, input logic [W-1:0] d,
                        input logic s, input string tag);
        logic [W-1:0] na, nb;
        {drv_en_n, cap_en_n, up_en_n, down_en_n, shift_en_n} = c;
        bus_in = d;
        ser_in = s;
        @(posedge clk);
        na = ma;
        nb = mb;
        if (rst) begin
            na = '0; nb = '0;
        end else begin
            if (!c[3])      na = d;
            else if (!c[2]) na = mb;
            if (!c[1])      nb = ma;
            else if (!c[0]) nb = {mb[W-2:0], s};
        end
        ma = na;
        mb = nb;
        @(negedge clk);
        check(tag, bus_out, ma, "bus_out");
        check(tag, {7'd0, ser_out}, {7'd0, mb[W-1]}, "ser_out");
        check(tag, {7'd0, bus_oe}, {7'd0, (!c[4] && c[3])}, "bus_oe");
    endtask

    task automatic drain(input string tag);
        for (int i = 0; i < W; i++) step(5'b01110, 8'h00, 1'b0, tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset under every control asserted
        step(5'b00000, 8'hFF, 1'b1, "R1");
        rst = 1'b0;
        drain("R1");
        // R2: capture, and capture beats transfer-up
        step(5'b10111, 8'hA5, 1'b0, "R2");
        step(5'b10011, 8'h3C, 1'b0, "R2");
        // R3: copy-down beats shift
        step(5'b11100, 8'h00, 1'b1, "R3");
        drain("R3");
        // R4: copy B up into A
        step(5'b10111, 8'h96, 1'b0, "R4");
        step(5'b11101, 8'h00, 1'b0, "R4");
        for (int i = 0; i < W; i++) step(5'b11110, 8'h00, i[0], "R6");
        step(5'b11011, 8'h00, 1'b0, "R4");
        // R5: swap, then swap with capture
        step(5'b10111, 8'hF0, 1'b0, "R5");
        step(5'b11001, 8'h00, 1'b0, "R5");
        step(5'b11011, 8'h00, 1'b0, "R5");
        step(5'b10001, 8'h1E, 1'b0, "R5");
        drain("R5");
        // R6: shift a pattern through
        for (int i = 0; i < W; i++) step(5'b11110, 8'h00, (i % 3) == 0, "R6");
        drain("R6");
        // R7: capture wins over drive
        step(5'b00111, 8'h5A, 1'b0, "R7");
        step(5'b01111, 8'h00, 1'b0, "R7");
        // R8: hold while drive and data toggle
        for (int i = 0; i < 4; i++) step({i[0], 4'b1111}, 8'(i * 37), i[1], "R8");
        // table walk
        for (int i = 0; i < 16; i++)
            step(VEC[i][13:9], VEC[i][8:1], VEC[i][0], "R5");
        drain("R3");
        // every control combination
        for (int c = 0; c < 32; c++)
            step(5'(c), 8'(c * 29 + 7), c[2], "R8");
        drain("R6");
        step(5'b11011, 8'h00, 1'b0, "R4");
        // R1: reset mid-run
        rst = 1'b1;
        step(5'b11111, 8'h00, 1'b0, "R1");
        rst = 1'b0;
        drain("R1");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule